// File: doc/BRIEF.md
# DMA Diagnostic Counters and Health Register

This block sits next to a streaming DMA engine and gives host software a way to find out what went wrong when the data stream misbehaves. It watches the handshake strobes of the two DMA data paths and keeps four counters. One counts words taken in from the host and one counts words handed to the host. A third counts underruns, where the transmit side needed a sample but the buffer the host fills was empty. The fourth counts saturation events, where the receive side had a word ready but the host link could not take it. The counters run all the time and saturate rather than wrap, so a rare transient fault leaves a mark that software can read long after it happened.

A health word reports whether any underrun or saturation has been seen since reset or the last clear. "Good" is a two-bit pattern (`10`) and "fault" is its complement (`01`), so the all-ones value that a failed host read returns can never be taken for a healthy device. Unmapped addresses read as zero for the same reason. Software reads all registers through a simple port with one cycle of read latency and a read-valid strobe. A single control write clears every counter and the fault flag together.

Top module: `dma_stat_regs`

## Requirements
- R1: After reset every counter reads 0, the health word reads 32'h0000_0002 and `reg_rvalid` is low.
- R2: The host-to-device counter (address 1) rises by one on each cycle with `h2d_beat` high, and the device-to-host counter (address 2) rises by one on each cycle with `d2h_beat` high.
- R3: The underrun counter (address 3) rises by one on each cycle where `tx_req` and `tx_empty` are both high.
- R4: The saturation counter (address 4) rises by one on each cycle where `rx_valid` is high and `rx_ready` is low.
- R5: Each counter is `CNT_W` bits wide (default 32), zero-extended on read, and stays at its maximum value instead of wrapping.
- R6: A write to address 0 with data bit 0 set zeroes all counters and the fault flag at that clock edge; an event in that same cycle leaves its counter at 1 (and sets the fault flag if it is an underrun or saturation). Writes with bit 0 clear, or to any other address, change nothing.
- R7: The health word (address 5) holds 2'b10 in bits [1:0] while no underrun or saturation has been counted since reset or the last clear and 2'b01 otherwise; bits [31:2] are zero, so it never reads as 2'b11 or all ones.
- R8: Address 0 reads as zero, and every address above 5 reads as 32'h0000_0000.
- R9: `reg_rvalid` is high exactly one cycle after a cycle with `reg_rd` high, and `reg_rdata` then holds the register value as it stood before the clock edge that accepted the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h2d_beat | input | 1 | One word accepted from the host this cycle |
| d2h_beat | input | 1 | One word delivered to the host this cycle |
| tx_req | input | 1 | Transmit path needs a sample this cycle |
| tx_empty | input | 1 | Host-fed transmit buffer is empty |
| rx_valid | input | 1 | Receive path has a word ready |
| rx_ready | input | 1 | Host link can accept a receive word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |

## Verification
On every cycle the assertions check the read strobe timing, that unmapped reads return zero, that the health word only ever carries one of its two legal patterns, that counters never move backwards or wrap outside a clear, that a clear leaves each counter at zero or one, and that underrun and saturation conditions each advance their counter by exactly one. The exact value software sees for each counter after mixed random traffic, the pre-update sampling of a read that coincides with an event or clear, and the saturation ceiling of a narrow counter can only be shown by the bench's scenarios, which compare every read against a model of the register file.

// File: rtl/dma_stat_pkg.sv
// Shared constants for the DMA diagnostic register block.
// Assumes: the register map is small enough to fit in any ADDR_W >= 3.
package dma_stat_pkg;
    localparam int NUM_CNT     = 4;
    localparam int IDX_H2D     = 0;
    localparam int IDX_D2H     = 1;
    localparam int IDX_UNDER   = 2;
    localparam int IDX_SAT     = 3;
    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_HEALTH = NUM_CNT + 1;

    typedef logic [1:0] health_t;
    localparam health_t HEALTH_OK  = 2'b10;
    localparam health_t HEALTH_BAD = 2'b01;
endpackage

// File: rtl/dma_sat_counter.sv
// Saturating event counter with a synchronous clear.
// Does: counts one per cycle with inc high, holds at all ones, and on clr
//       restarts at 1 if inc is also high, else at 0.
// Assumes: W >= 2.
module dma_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // Count register: clear has priority, then saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= inc ? ONE : '0;
        end else if (inc && (count != MAXV)) begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/dma_health_tracker.sv
// Sticky fault flag turned into a two-bit health code.
// Does: remembers any fault event since reset or clear; reports HEALTH_OK
//       (2'b10) or HEALTH_BAD (2'b01), never all ones.
// Assumes: a fault in the clearing cycle survives the clear.
module dma_health_tracker
    import dma_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    fault_evt,
    output health_t code
);
    logic fault_q;

    // Sticky flag: set by any fault, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (clr) begin
            fault_q <= fault_evt;
        end else begin
            fault_q <= fault_q | fault_evt;
        end
    end

    // Encode flag as one of two complementary patterns.
    always_comb begin
        code = fault_q ? HEALTH_BAD : HEALTH_OK;
    end
endmodule

// File: rtl/dma_reg_readout.sv
// Read mux and one-cycle read pipeline for the diagnostic registers.
// Does: selects counter or health word by address, zero for anything
//       unmapped, and registers it together with a valid strobe.
// Assumes: CNT_W <= DATA_W; counters are zero-extended.
module dma_reg_readout
    import dma_stat_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   counts,
    input  health_t                         health,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rvalid
);
    localparam logic [ADDR_W-1:0] HEALTH_A = ADDR_W'(ADDR_HEALTH);

    logic [DATA_W-1:0] mux_val;

    // Address decode: counters at 1..NUM_CNT, health after them, else zero.
    always_comb begin
        mux_val = '0;
        if (addr == HEALTH_A) begin
            mux_val = DATA_W'(health);
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADDR_W'(i + 1)) begin
                mux_val = DATA_W'(counts[i]);
            end
        end
    end

    // Read pipeline: capture selected value and flag it valid next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd) begin
                rdata <= mux_val;
            end
        end
    end
endmodule

// File: rtl/dma_stat_regs.sv
// DMA diagnostic register block (top).
// Does: turns DMA path strobes into four saturating counters and a health
//       word; exposes them on a register port with one cycle read latency.
// Assumes: all inputs are synchronous to clk; reset is synchronous low.
module dma_stat_regs
    import dma_stat_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h2d_beat,
    input  logic              d2h_beat,
    input  logic              tx_req,
    input  logic              tx_empty,
    input  logic              rx_valid,
    input  logic              rx_ready,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid
);
    logic [NUM_CNT-1:0]            evt;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic                          clr_fire;
    health_t                       health;
    logic                          unused_wdata;

    // Event decode: one strobe per counter.
    always_comb begin
        evt            = '0;
        evt[IDX_H2D]   = h2d_beat;
        evt[IDX_D2H]   = d2h_beat;
        evt[IDX_UNDER] = tx_req & tx_empty;
        evt[IDX_SAT]   = rx_valid & ~rx_ready;
    end

    // Clear decode: bit 0 written to the control address.
    always_comb begin
        clr_fire = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL)) && reg_wdata[0];
    end

    assign unused_wdata = ^reg_wdata[DATA_W-1:1];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        dma_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_fire),
            .inc   (evt[g]),
            .count (cnt[g])
        );
    end

    dma_health_tracker u_health (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_fire),
        .fault_evt (evt[IDX_UNDER] | evt[IDX_SAT]),
        .code      (health)
    );

    dma_reg_readout #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .counts (cnt),
        .health (health),
        .rdata  (reg_rdata),
        .rvalid (reg_rvalid)
    );
endmodule

// File: rtl/dma_stat_checker.sv
// Property checker for dma_stat_regs, attached with bind.
// Does: checks read timing, map rules, health encoding and counter motion.
// Assumes: observes the top's ports plus its counter and clear nets.
module dma_stat_checker
    import dma_stat_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_rd,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [DATA_W-1:0]             reg_rdata,
    input logic                          reg_rvalid,
    input logic                          tx_req,
    input logic                          tx_empty,
    input logic                          rx_valid,
    input logic                          rx_ready,
    input logic                          clr_fire,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0]  MAXV     = '1;
    localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);
    localparam logic [ADDR_W-1:0] HEALTH_A = ADDR_W'(ADDR_HEALTH);

    assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr > HEALTH_A) |=> (reg_rdata == '0));

    assert_health_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == HEALTH_A) |=>
            ((reg_rdata[1:0] == HEALTH_OK || reg_rdata[1:0] == HEALTH_BAD)
             && reg_rdata[DATA_W-1:2] == '0));

    assert_underrun_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_fire && tx_req && tx_empty && cnt[IDX_UNDER] != MAXV) |=>
            (cnt[IDX_UNDER] == $past(cnt[IDX_UNDER]) + ONE));

    assert_saturation_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_fire && rx_valid && !rx_ready && cnt[IDX_SAT] != MAXV) |=>
            (cnt[IDX_SAT] == $past(cnt[IDX_SAT]) + ONE));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_prop
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_fire && cnt[g] == MAXV) |=> (cnt[g] == MAXV));

        assert_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_fire |=> (cnt[g] >= $past(cnt[g])));

        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            clr_fire |=> (cnt[g] <= ONE));
    end
endmodule

bind dma_stat_regs dma_stat_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .tx_req     (tx_req),
    .tx_empty   (tx_empty),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .clr_fire   (clr_fire),
    .cnt        (cnt)
);

// File: tb/sim_dma_stat_regs.sv
// Bench for dma_stat_regs: u0 at default width, u1 with 6-bit counters
// sharing the same stimulus so the saturation ceiling is reachable.
module sim_dma_stat_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h2d_beat = 0, d2h_beat = 0, tx_req = 0, tx_empty = 0;
    logic        rx_valid = 0, rx_ready = 1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        rvalid0, rvalid1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint m0 [4];
    longint m1 [4];
    bit     fault_m;

    always #2.5 clk = ~clk;

    dma_stat_regs u0 (
        .clk(clk), .rst_n(rst_n), .h2d_beat(h2d_beat), .d2h_beat(d2h_beat),
        .tx_req(tx_req), .tx_empty(tx_empty), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata0), .reg_rvalid(rvalid0)
    );

    dma_stat_regs #(.CNT_W(6)) u1 (
        .clk(clk), .rst_n(rst_n), .h2d_beat(h2d_beat), .d2h_beat(d2h_beat),
        .tx_req(tx_req), .tx_empty(tx_empty), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata1), .reg_rvalid(rvalid1)
    );

    function automatic logic [31:0] exp_read(input int a, input bit narrow);
        if (a >= 1 && a <= 4) return narrow ? 32'(m1[a-1]) : 32'(m0[a-1]);
        if (a == 5) return fault_m ? 32'h1 : 32'h2;
        return 32'h0;
    endfunction

    function automatic string tag_of(input int a);
        if (a == 1 || a == 2) return "R2";
        if (a == 3) return "R3";
        if (a == 4) return "R4";
        if (a == 5) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_update();
        bit ev [4];
        bit clr;
        clr   = reg_wr && reg_addr == 4'd0 && reg_wdata[0];
        ev[0] = h2d_beat;
        ev[1] = d2h_beat;
        ev[2] = tx_req && tx_empty;
        ev[3] = rx_valid && !rx_ready;
        for (int i = 0; i < 4; i++) begin
            if (clr) begin
                m0[i] = ev[i] ? 1 : 0;
                m1[i] = ev[i] ? 1 : 0;
            end else if (ev[i]) begin
                if (m0[i] != 64'hFFFF_FFFF) m0[i]++;
                if (m1[i] != 63) m1[i]++;
            end
        end
        fault_m = clr ? (ev[2] | ev[3]) : (fault_m | ev[2] | ev[3]);
    endtask

    // One cycle: inputs are already driven (at a negedge).
    task automatic tick(input string tag_override);
        logic [31:0] e0, e1;
        bit pend;
        int pa;
        string t;
        pend = reg_rd;
        pa   = int'(reg_addr);
        e0   = exp_read(pa, 0);
        e1   = exp_read(pa, 1);
        model_update();
        @(posedge clk);
        @(negedge clk);
        t = (tag_override != "") ? tag_override : tag_of(pa);
        if (pend) begin
            check("R9", {31'b0, rvalid0}, 32'h1);
            check(t, rdata0, e0);
            check(t, rdata1, e1);
        end else begin
            check("R9", {31'b0, rvalid0}, 32'h0);
        end
    endtask

    task automatic idle_inputs();
        h2d_beat = 0; d2h_beat = 0; tx_req = 0; tx_empty = 0;
        rx_valid = 0; rx_ready = 1; reg_wr = 0; reg_rd = 0;
        reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic do_read(input int a, input string tag_override);
        idle_inputs();
        reg_rd = 1;
        reg_addr = 4'(a);
        tick(tag_override);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240117));
        for (int i = 0; i < 4; i++) begin m0[i] = 0; m1[i] = 0; end
        fault_m = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", {31'b0, rvalid0}, 32'h0);
        do_read(5, "R1");
        for (int a = 1; a <= 4; a++) do_read(a, "R1");

        // R8: control address and unmapped space read as zero
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a > 5) do_read(a, "R8");
        end

        // R2: directed beats on both directions
        idle_inputs(); h2d_beat = 1; d2h_beat = 1; tick("");
        idle_inputs(); h2d_beat = 1; tick("");
        do_read(1, "R2");
        do_read(2, "R2");

        // R3 / R7: one underrun flips health to 2'b01
        idle_inputs(); tx_req = 1; tx_empty = 1; tick("");
        idle_inputs(); tx_req = 1; tx_empty = 0; tick("");
        do_read(3, "R3");
        do_read(5, "R7");

        // R4: saturation counted only when receive is stalled
        idle_inputs(); rx_valid = 1; rx_ready = 0; tick("");
        idle_inputs(); rx_valid = 1; rx_ready = 1; tick("");
        do_read(4, "R4");

        // R9: read in the same cycle as an event returns the old value
        idle_inputs(); reg_rd = 1; reg_addr = 4'd1; h2d_beat = 1; tick("R9");
        do_read(1, "R9");

        // R6: write with bit 0 clear changes nothing
        idle_inputs(); reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFE; tick("");
        idle_inputs(); reg_wr = 1; reg_addr = 4'd3; reg_wdata = 32'hFFFF_FFFF; tick("");
        do_read(1, "R6");
        do_read(3, "R6");

        // R6: clear with a simultaneous beat leaves that counter at 1
        idle_inputs(); reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h1; h2d_beat = 1; tick("");
        do_read(1, "R6");
        do_read(2, "R6");
        do_read(5, "R6");

        // R5: narrow counters stop at their maximum
        for (int k = 0; k < 70; k++) begin
            idle_inputs(); h2d_beat = 1; tick("");
        end
        do_read(1, "R5");

        // Constrained random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            h2d_beat = 1'($urandom % 2);
            d2h_beat = 1'($urandom % 2);
            tx_req   = 1'($urandom % 2);
            tx_empty = 1'(($urandom % 4) == 0);
            rx_valid = 1'($urandom % 2);
            rx_ready = 1'(($urandom % 4) != 0);
            reg_rd   = 1'($urandom % 2);
            reg_wr   = 1'(($urandom % 40) == 0);
            reg_addr = 4'($urandom % 16);
            reg_wdata = $urandom;
            tick("");
        end
        do_read(5, "R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule